// File: doc/BRIEF.md
# Effective Address Generator

This unit turns one decoded instruction's addressing information into a 16-bit effective address. On each request it takes an addressing-mode code, a page code, up to two operand bytes and the two index registers. It also takes two program-counter values: the location of the first operand byte, and the first byte after the whole instruction. One adder, fed by two multiplexers, forms every result. The result is registered and returned one cycle later, with a flag that says whether the mode yields an address at all.

A new request may arrive on every cycle, so the unit sits in a decode pipeline without stalling it. Relative mode shares the adder to form branch targets. This unit does not evaluate branch conditions, access memory or write registers.

Top module: `ea_gen`

## Requirements
- R1: A request seen with `req_vld` high at a rising clock edge gives `rsp_vld` high for exactly the following cycle. Requests on consecutive cycles give responses on consecutive cycles.
- R2: While `rsp_vld` is low, including directly after reset, `rsp_ea` is zero and `rsp_has_ea` is low.
- R3: In direct mode (`req_mode` = 2) the address is `{8'h00, op0}`.
- R4: In extended mode (`req_mode` = 3) the address is `{op0, op1}`, with `op0` as the high byte.
- R5: In indexed mode (`req_mode` = 4) the address is the selected index register plus `op0` zero-extended, modulo 65536.
- R6: The page code `req_page` selects the index register: codes 1 and 3 select `idx_y`, and codes 0 and 2 select `idx_x`. The page code has no effect in any other mode.
- R7: In relative mode (`req_mode` = 5) the address is `next_pc` plus `op0` sign-extended, modulo 65536.
- R8: In immediate mode (`req_mode` = 1) the address equals `opnd_pc`.
- R9: Inherent mode (`req_mode` = 0) and the unused codes 6 and 7 respond with `rsp_vld` high, `rsp_has_ea` low and `rsp_ea` zero.
- R10: `rsp_has_ea` is high on every response for modes 1 to 5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_vld | input | 1 | Request strobe |
| req_mode | input | 3 | Addressing mode: 0 inherent, 1 immediate, 2 direct, 3 extended, 4 indexed, 5 relative |
| req_page | input | 2 | Opcode page code: 0 base, 1 and 3 use Y, 2 uses X |
| op0 | input | 8 | First operand byte: address low byte, offset, or extended high byte |
| op1 | input | 8 | Second operand byte: extended low byte |
| idx_x | input | 16 | Index register X |
| idx_y | input | 16 | Index register Y |
| opnd_pc | input | 16 | Address of the byte after the opcode |
| next_pc | input | 16 | Address of the first byte after the whole instruction |
| rsp_vld | output | 1 | Response strobe, one cycle after the request |
| rsp_ea | output | 16 | Effective address |
| rsp_has_ea | output | 1 | High when the mode produces an address |

## Verification
The assertions assume that `req_mode`, `req_page` and the operand inputs are defined whenever `req_vld` is high. They make no assumption about these inputs in idle cycles. The stimulus drives every input to a known value in every cycle. It changes inputs only on the falling clock edge. It sweeps every mode and page code against all 256 values of `op0`, and it uses base values that make the adder wrap past 16#FFFF# in both directions. Idle gaps are placed between request bursts, so the cleared idle outputs are observed as well.

// File: rtl/ea_gen.sv
module ea_gen #(
  parameter int BW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_vld,
  input  logic [2:0]      req_mode,
  input  logic [1:0]      req_page,
  input  logic [BW-1:0]   op0,
  input  logic [BW-1:0]   op1,
  input  logic [2*BW-1:0] idx_x,
  input  logic [2*BW-1:0] idx_y,
  input  logic [2*BW-1:0] opnd_pc,
  input  logic [2*BW-1:0] next_pc,
  output logic            rsp_vld,
  output logic [2*BW-1:0] rsp_ea,
  output logic            rsp_has_ea
);
  localparam int AW = 2 * BW;
  localparam logic [2:0] M_IMM = 3'd1, M_DIR = 3'd2, M_EXT = 3'd3,
                         M_IDX = 3'd4, M_REL = 3'd5;

  logic [AW-1:0] base, offs, sum, idx_sel;
  logic          has_ea;

  assign idx_sel = req_page[0] ? idx_y : idx_x;
  assign has_ea  = (req_mode >= M_IMM) && (req_mode <= M_REL);

  always_comb begin
    base = '0;
    offs = '0;
    unique case (req_mode)
      M_IMM: base = opnd_pc;
      M_DIR: offs = {{BW{1'b0}}, op0};
      M_EXT: offs = {op0, op1};
      M_IDX: begin base = idx_sel; offs = {{BW{1'b0}}, op0}; end
      M_REL: begin base = next_pc; offs = {{BW{op0[BW-1]}}, op0}; end
      default: ;
    endcase
  end

  assign sum = base + offs;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_vld    <= 1'b0;
      rsp_ea     <= '0;
      rsp_has_ea <= 1'b0;
    end else begin
      rsp_vld    <= req_vld;
      rsp_has_ea <= req_vld && has_ea;
      rsp_ea     <= (req_vld && has_ea) ? sum : '0;
    end
  end

  // R1
  rsp_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_vld |=> rsp_vld);
  // R2
  idle_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_vld |-> (rsp_ea == '0 && !rsp_has_ea));
  // R3
  dir_page_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_vld && req_mode == M_DIR) |=> (rsp_ea[AW-1:BW] == '0 && rsp_ea[BW-1:0] == $past(op0)));
  // R4
  ext_bytes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_vld && req_mode == M_EXT) |=> (rsp_ea == {$past(op0), $past(op1)}));
  // R8
  imm_loc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_vld && req_mode == M_IMM) |=> (rsp_ea == $past(opnd_pc)));
  // R9
  inh_none_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_vld && !has_ea) |=> (rsp_vld && !rsp_has_ea && rsp_ea == '0));
  // R10
  has_ea_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_vld && req_mode >= M_IMM && req_mode <= M_REL) |=> rsp_has_ea);
endmodule

// File: tb/sim_ea_gen.sv
module sim_ea_gen;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_vld = 1'b0;
  logic [2:0]  req_mode = '0;
  logic [1:0]  req_page = '0;
  logic [7:0]  op0 = '0, op1 = '0;
  logic [15:0] idx_x = '0, idx_y = '0, opnd_pc = '0, next_pc = '0;
  logic        rsp_vld, rsp_has_ea;
  logic [15:0] rsp_ea;

  int total = 0;
  int bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ea_gen u0 (
    .clk(clk), .rst_n(rst_n), .req_vld(req_vld), .req_mode(req_mode),
    .req_page(req_page), .op0(op0), .op1(op1), .idx_x(idx_x), .idx_y(idx_y),
    .opnd_pc(opnd_pc), .next_pc(next_pc),
    .rsp_vld(rsp_vld), .rsp_ea(rsp_ea), .rsp_has_ea(rsp_has_ea)
  );

  function automatic string tag_of(input int m, input int pg);
    case (m)
      1: return "R8";
      2: return "R3";
      3: return "R4";
      4: return (pg % 2 == 1) ? "R6" : "R5";
      5: return "R7";
      default: return "R9";
    endcase
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // one request per call, checked on the following falling edge
  task automatic cyc(input bit v, input int m, input int pg, input int a, input int b,
                     input int x, input int y, input int ipc, input int npc);
    int ex, eh, sgn, ix;
    req_vld = v; req_mode = 3'(m); req_page = 2'(pg);
    op0 = 8'(a); op1 = 8'(b); idx_x = 16'(x); idx_y = 16'(y);
    opnd_pc = 16'(ipc); next_pc = 16'(npc);
    sgn = (a >= 128) ? a - 256 : a;
    ix  = (pg == 1 || pg == 3) ? y : x;
    eh = 1;
    case (m)
      1: ex = ipc;
      2: ex = a;
      3: ex = a * 256 + b;
      4: ex = (ix + a) % 65536;
      5: ex = (npc + sgn + 65536) % 65536;
      default: begin ex = 0; eh = 0; end
    endcase
    if (!v) begin ex = 0; eh = 0; end
    @(posedge clk); @(negedge clk);
    if (v) begin
      check("R1", int'(rsp_vld), 1);
      check(m >= 1 && m <= 5 ? "R10" : "R9", int'(rsp_has_ea), eh);
      check(tag_of(m, pg), int'(rsp_ea), ex);
    end else begin
      check("R1", int'(rsp_vld), 0);
      check("R2", int'(rsp_ea), 0);
      check("R2", int'(rsp_has_ea), 0);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R2 reset state
    check("R2", int'(rsp_vld), 0);
    check("R2", int'(rsp_ea), 0);
    check("R2", int'(rsp_has_ea), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R2", int'(rsp_ea), 0);
    for (int m = 0; m < 8; m++) begin
      for (int pg = 0; pg < 4; pg++) begin
        for (int a = 0; a < 256; a++) begin
          cyc(1, m, pg, a, (a * 37 + 11) % 256, 16'hFF80 + pg, 16'h1230 + 64 * pg,
              (a * 257) % 65536, (a % 2 == 0) ? 16'h0005 : 16'hFFF0);
        end
        cyc(0, m, pg, 8'hFF, 8'hFF, 16'hFFFF, 16'hFFFF, 16'hFFFF, 16'hFFFF);
      end
    end
    // R6 page code ignored outside indexed mode, distinct X and Y
    for (int pg = 0; pg < 4; pg++) begin
      cyc(1, 2, pg, 8'h5A, 8'h00, 16'h1000, 16'h2000, 16'h3000, 16'h4000);
      cyc(1, 3, pg, 8'h12, 8'h34, 16'h1000, 16'h2000, 16'h3000, 16'h4000);
      cyc(1, 5, pg, 8'h80, 8'h00, 16'h1000, 16'h2000, 16'h3000, 16'h0010);
      cyc(1, 4, pg, 8'hFF, 8'h00, 16'hFFFF, 16'h0000, 16'h3000, 16'h4000);
    end
    cyc(0, 0, 0, 0, 0, 0, 0, 0, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule